// File: doc/BRIEF.md
# Three-Port Programmable Parallel Interface

This block is a bus-mapped parallel peripheral with three 8-bit pin ports, called A, B and C, and one control register. The pins are split into two groups. The first group is port A together with port C bits 7..4. The second group is port B together with port C bits 3..0. Each group takes its own mode and its own direction settings from a single control write. A second kind of control write sets or clears one port C bit, so software can change a single line without touching the others.

Each group can run in one of three modes:

- **Plain I/O.** There is no handshake. The port and its half of port C are each set as input or output on their own.
- **Strobed I/O.** The port moves data in one direction only. The handshake lines sit on fixed port C pins.
- **Bidirectional (first group only).** Port A carries data both ways and shares its bus with an external agent.

The pads are modelled as three separate vectors per port: output value, output enable and pin input. Any external tristate cell can be wired to them.

Top module: `tri_port_pio`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A read of address 3 returns the current setup word, with bit 7 set.
- R2: After reset, no pin is driven, all output latches are 0, and the control register reads 8'h9B. That is plain mode for both groups, with every port an input. An input port in plain mode reads its pins live.
- R3: A setup word has bit 7 = 1. Its fields are:
  - bits 6:5: first-group mode (00 plain, 01 strobed, 1x bidirectional);
  - bit 4: port A direction (1 = input);
  - bit 3: direction of port C bits 7..4;
  - bit 2: second-group mode (0 plain, 1 strobed);
  - bit 1: port B direction;
  - bit 0: direction of port C bits 3..0.

  An output port drives its latch on every pin, with enable all ones, and reads back the latch.
- R4: Writing a setup word clears the port A, B and C output latches and drops all handshake state. Every buffer-full line returns high, and every input-full and interrupt line returns low.
- R5: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 pick the port C bit and bit 0 gives its new value. No other port C bit changes, and the control register keeps its value.
- R6: In strobed input mode, port A uses three port C pins:
  - A low level on C4 (strobe) latches pa_in and drives C5 (input full) high.
  - When C4 returns high while C5 is high, C3 (interrupt) goes high.
  - Reading port A returns the latched byte, not the live pins. The read clears C5 and C3.
- R7: In strobed output mode, port A uses three port C pins:
  - A write to port A drives the new byte and pulls C7 (buffer full, active low) low and C3 low.
  - A low level on C6 (acknowledge) returns C7 high.
  - When C6 rises after that, C3 goes high.
- R8: In strobed mode, port B uses C2 as its strobe or acknowledge input and C0 as its interrupt. C1 is input full (high when full) in input mode, and buffer full (active low) in output mode. The rules are otherwise those of R6 and R7.
- R9: In bidirectional mode, the two port A handshakes run together:
  - Port A is driven only while C6 is low.
  - The output handshake uses C7 and C6; the input handshake uses C4 and C5.
  - C3 is high while either direction has its interrupt pending.
- R10: Port C pins that carry a handshake line ignore port C data writes and single-bit commands. A port C read returns, for each bit, the driven value if its enable is set and the pin input otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus select |
| wr | input | 1 | Write strobe (with cs) |
| rd | input | 1 | Read strobe (with cs); has side effects on handshake state |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output value |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output value |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C pin output value |
| pc_oe | output | 8 | Port C output enable |

## Verification
Any stuck or stale handshake flag shows up on a port C pin in the clock cycle after the event that should have changed it. Examples are a strobe, an acknowledge, or a read or write of port A or B. An error in the pin-role masks shows on pc_oe and pc_out as soon as the setup word is written, because those outputs are combinational from the control register. A latch that is not cleared by a setup write is visible on pa_out, pb_out or pc_out on the very next cycle. The bench therefore samples pins one cycle after each stimulus and checks the enables immediately after each mode change.

// File: rtl/tri_port_pio.sv
module tri_port_pio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam logic [1:0] AD_A = 2'd0, AD_B = 2'd1, AD_C = 2'd2, AD_CTL = 2'd3;

  logic [1:0] ma;
  logic       a_dir_in, cu_in, mb, b_dir_in, cl_in;
  logic [7:0] pa_lat, pb_lat, pc_lat, a_ilat, b_ilat;
  logic       a_ibf, a_obf, a_iint, a_oint, b_ibf, b_obf, b_int;
  logic       stb_a_q, ack_a_q, hs_b_q;

  logic wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  assign wr_a   = cs && wr && addr == AD_A;
  assign wr_b   = cs && wr && addr == AD_B;
  assign wr_c   = cs && wr && addr == AD_C;
  assign wr_ctl = cs && wr && addr == AD_CTL;
  assign rd_a   = cs && rd && addr == AD_A;
  assign rd_b   = cs && rd && addr == AD_B;

  logic a_m1, a_m2, a_ins, a_outs, b_ins, b_outs;
  assign a_m1   = ma == 2'b01;
  assign a_m2   = ma[1];
  assign a_ins  = a_m2 || (a_m1 && a_dir_in);
  assign a_outs = a_m2 || (a_m1 && !a_dir_in);
  assign b_ins  = mb && b_dir_in;
  assign b_outs = mb && !b_dir_in;

  logic stb_a_n, ack_a_n, hs_b_n;
  assign stb_a_n = pc_in[4];
  assign ack_a_n = pc_in[6];
  assign hs_b_n  = pc_in[2];

  logic [7:0] hs_mask, hs_oe, hs_val, dir_oe;
  assign hs_mask = (a_m2 ? 8'hF8 : a_ins ? 8'h38 : a_outs ? 8'hC8 : 8'h00)
                 | (mb ? 8'h07 : 8'h00);
  assign hs_oe   = (a_m2 ? 8'hA8 : a_ins ? 8'h28 : a_outs ? 8'h88 : 8'h00)
                 | (mb ? 8'h03 : 8'h00);
  assign dir_oe  = {{4{!cu_in}}, {4{!cl_in}}};

  always_comb begin
    hs_val    = '0;
    hs_val[7] = !a_obf;
    hs_val[5] = a_ibf;
    hs_val[3] = a_iint || a_oint;
    hs_val[1] = b_dir_in ? b_ibf : !b_obf;
    hs_val[0] = b_int;
  end

  assign pc_oe  = hs_oe | (~hs_mask & dir_oe);
  assign pc_out = (hs_mask & hs_val) | (~hs_mask & pc_lat);
  assign pa_oe  = a_m2 ? {8{!ack_a_n}} : {8{!a_dir_in}};
  assign pa_out = pa_lat;
  assign pb_oe  = {8{!b_dir_in}};
  assign pb_out = pb_lat;

  always_comb begin
    case (addr)
      AD_A:    rdata = a_ins ? a_ilat : (a_dir_in ? pa_in : pa_lat);
      AD_B:    rdata = b_ins ? b_ilat : (b_dir_in ? pb_in : pb_lat);
      AD_C:    rdata = (pc_oe & pc_out) | (~pc_oe & pc_in);
      default: rdata = {1'b1, ma, a_dir_in, cu_in, mb, b_dir_in, cl_in};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ma, a_dir_in, cu_in, mb, b_dir_in, cl_in} <= 7'b0011011;
      pa_lat <= '0; pb_lat <= '0; pc_lat <= '0; a_ilat <= '0; b_ilat <= '0;
      a_ibf <= 1'b0; a_obf <= 1'b0; a_iint <= 1'b0; a_oint <= 1'b0;
      b_ibf <= 1'b0; b_obf <= 1'b0; b_int <= 1'b0;
      stb_a_q <= 1'b1; ack_a_q <= 1'b1; hs_b_q <= 1'b1;
    end else begin
      stb_a_q <= stb_a_n;
      ack_a_q <= ack_a_n;
      hs_b_q  <= hs_b_n;
      if (wr_ctl && wdata[7]) begin
        {ma, a_dir_in, cu_in, mb, b_dir_in, cl_in} <= wdata[6:0];
        pa_lat <= '0; pb_lat <= '0; pc_lat <= '0; a_ilat <= '0; b_ilat <= '0;
        a_ibf <= 1'b0; a_obf <= 1'b0; a_iint <= 1'b0; a_oint <= 1'b0;
        b_ibf <= 1'b0; b_obf <= 1'b0; b_int <= 1'b0;
      end else begin
        if (wr_ctl && !hs_mask[wdata[3:1]])
          pc_lat[wdata[3:1]] <= wdata[0];
        if (wr_c)
          pc_lat <= (pc_lat & hs_mask) | (wdata & ~hs_mask);
        if (wr_a) pa_lat <= wdata;
        if (wr_b) pb_lat <= wdata;

        if (rd_a) begin a_ibf <= 1'b0; a_iint <= 1'b0; end
        if (a_ins && !stb_a_n) begin a_ilat <= pa_in; a_ibf <= 1'b1; end
        if (a_ins && stb_a_n && !stb_a_q && a_ibf) a_iint <= 1'b1;

        if (a_outs && wr_a) begin a_obf <= 1'b1; a_oint <= 1'b0; end
        else if (a_outs && !ack_a_n) a_obf <= 1'b0;
        if (a_outs && ack_a_n && !ack_a_q && !a_obf && !wr_a) a_oint <= 1'b1;

        if (b_ins) begin
          if (rd_b) begin b_ibf <= 1'b0; b_int <= 1'b0; end
          if (!hs_b_n) begin b_ilat <= pb_in; b_ibf <= 1'b1; end
          if (hs_b_n && !hs_b_q && b_ibf) b_int <= 1'b1;
        end
        if (b_outs) begin
          if (wr_b) begin b_obf <= 1'b1; b_int <= 1'b0; end
          else if (!hs_b_n) b_obf <= 1'b0;
          if (hs_b_n && !hs_b_q && !b_obf && !wr_b) b_int <= 1'b1;
        end
      end
    end
  end
endmodule

module tri_port_pio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_in,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe,
  input logic [7:0] hs_mask,
  input logic       a_ins,
  input logic       mb,
  input logic       b_dir_in
);
  // R4
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00));

  // R5
  bit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && !wdata[7] && !hs_mask[wdata[3:1]])
    |=> pc_out[$past(wdata[3:1])] == $past(wdata[0]));

  // R6
  strobe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ins && !pc_in[4] && !(cs && wr && addr == 2'd3 && wdata[7])) |=> pc_out[5]);

  // R6
  strobe_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_ins |-> !pc_oe[4]);

  // R3
  b_plain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mb && !b_dir_in) |-> pb_oe == 8'hFF);
endmodule

bind tri_port_pio tri_port_pio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
  .pa_out(pa_out), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
  .pc_out(pc_out), .pc_oe(pc_oe), .hs_mask(hs_mask), .a_ins(a_ins),
  .mb(mb), .b_dir_in(b_dir_in)
);

// File: tb/tb_tri_port_pio.sv
module tb_tri_port_pio;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0, pc_in = 8'hFF;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  tri_port_pio dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0; #1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0; #1;
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R2 pa_oe", pa_oe, 8'h00);
    chk("R2 pb_oe", pb_oe, 8'h00);
    chk("R2 pc_oe", pc_oe, 8'h00);
    bus_rd(2'd3, d); chk("R2 ctrl", d, 8'h9B);
    pa_in = 8'h5A;
    bus_rd(2'd0, d); chk("R2 live read A", d, 8'h5A);
  endtask

  task automatic t_plain;
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    chk("R3 pa_oe", pa_oe, 8'hFF);
    chk("R3 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h3C); chk("R1 pa_out", pa_out, 8'h3C);
    bus_rd(2'd0, d); chk("R3 read latch A", d, 8'h3C);
    bus_wr(2'd1, 8'h6E); chk("R1 pb_out", pb_out, 8'h6E);
    bus_wr(2'd2, 8'hA5); chk("R1 pc_out", pc_out, 8'hA5);
    bus_wr(2'd3, 8'h8A);
    chk("R4 pa_out cleared", pa_out, 8'h00);
    chk("R4 pc_out cleared", pc_out, 8'h00);
    chk("R3 pb_oe input", pb_oe, 8'h00);
    chk("R3 pc_oe split", pc_oe, 8'h0F);
    pb_in = 8'hD2;
    bus_rd(2'd1, d); chk("R3 live read B", d, 8'hD2);
    bus_rd(2'd3, d); chk("R1 ctrl readback", d, 8'h8A);
  endtask

  task automatic t_bitcmd;
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0B); chk("R5 set C5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h0F); chk("R5 set C7", pc_out, 8'hA0);
    bus_wr(2'd3, 8'h0A); chk("R5 clear C5", pc_out, 8'h80);
    bus_rd(2'd3, d); chk("R5 ctrl kept", d, 8'h80);
  endtask

  task automatic t_a_in;
    logic [7:0] d;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hB0);
    chk("R6 pa_oe", pa_oe, 8'h00);
    chk("R6 pc_oe", pc_oe, 8'hEF);
    @(negedge clk); pa_in = 8'h77; pc_in[4] = 0;
    step; chk("R6 ibf", {7'd0, pc_out[5]}, 8'd1);
    chk("R6 no intr yet", {7'd0, pc_out[3]}, 8'd0);
    pc_in[4] = 1; pa_in = 8'h11;
    step; chk("R6 intr", {7'd0, pc_out[3]}, 8'd1);
    bus_rd(2'd0, d); chk("R6 latched read", d, 8'h77);
    chk("R6 ibf cleared", {7'd0, pc_out[5]}, 8'd0);
    chk("R6 intr cleared", {7'd0, pc_out[3]}, 8'd0);
  endtask

  task automatic t_a_out;
    logic [7:0] d;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hA0);
    chk("R4 obf idle high", {7'd0, pc_out[7]}, 8'd1);
    bus_wr(2'd0, 8'h5C);
    chk("R7 data", pa_out, 8'h5C);
    chk("R7 obf low", {7'd0, pc_out[7]}, 8'd0);
    @(negedge clk); pc_in[6] = 0;
    step; chk("R7 obf released", {7'd0, pc_out[7]}, 8'd1);
    chk("R7 intr waits", {7'd0, pc_out[3]}, 8'd0);
    pc_in[6] = 1;
    step; chk("R7 intr", {7'd0, pc_out[3]}, 8'd1);
    bus_wr(2'd0, 8'h01); chk("R7 intr cleared", {7'd0, pc_out[3]}, 8'd0);
    bus_wr(2'd2, 8'hFF); chk("R10 hs bits hold", pc_out, 8'h37);
    bus_wr(2'd3, 8'h0F); chk("R10 bit cmd ignored", pc_out, 8'h37);
    bus_rd(2'd2, d); chk("R10 C read", d, 8'h77);
  endtask

  task automatic t_b;
    logic [7:0] d;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'h86);
    chk("R8 pb_oe", pb_oe, 8'h00);
    @(negedge clk); pb_in = 8'hC3; pc_in[2] = 0;
    step; chk("R8 ibf", {6'd0, pc_out[1:0]}, 8'd2);
    pc_in[2] = 1; pb_in = 8'h00;
    step; chk("R8 intr", {6'd0, pc_out[1:0]}, 8'd3);
    bus_rd(2'd1, d); chk("R8 latched read", d, 8'hC3);
    chk("R8 cleared", {6'd0, pc_out[1:0]}, 8'd0);
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd1, 8'h99);
    chk("R8 out data", pb_out, 8'h99);
    chk("R8 obf low", {6'd0, pc_out[1:0]}, 8'd0);
    @(negedge clk); pc_in[2] = 0;
    step; chk("R8 ack", {6'd0, pc_out[1:0]}, 8'd2);
    pc_in[2] = 1;
    step; chk("R8 out intr", {6'd0, pc_out[1:0]}, 8'd3);
  endtask

  task automatic t_bidir;
    logic [7:0] d;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hC0);
    chk("R9 bus released", pa_oe, 8'h00);
    bus_wr(2'd0, 8'h42); chk("R9 obf low", {7'd0, pc_out[7]}, 8'd0);
    @(negedge clk); pc_in[6] = 0; #1;
    chk("R9 drive on ack", pa_oe, 8'hFF);
    chk("R9 data", pa_out, 8'h42);
    step; chk("R9 obf released", {7'd0, pc_out[7]}, 8'd1);
    pc_in[6] = 1;
    step; chk("R9 out intr", {7'd0, pc_out[3]}, 8'd1);
    chk("R9 bus released again", pa_oe, 8'h00);
    pa_in = 8'h24; pc_in[4] = 0;
    step; chk("R9 ibf", {7'd0, pc_out[5]}, 8'd1);
    pc_in[4] = 1;
    step;
    bus_rd(2'd0, d); chk("R9 latched read", d, 8'h24);
    chk("R9 intr or", {7'd0, pc_out[3]}, 8'd1);
    bus_wr(2'd0, 8'h00); chk("R9 intr cleared", {7'd0, pc_out[3]}, 8'd0);
    bus_wr(2'd3, 8'hC0); chk("R4 pending obf dropped", {7'd0, pc_out[7]}, 8'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset;
    t_plain;
    t_bitcmd;
    t_a_in;
    t_a_out;
    t_b;
    t_bidir;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule